// File: doc/BRIEF.md
# Device Power State and Wake Event Controller

This block holds the power-management control and status word of one function and carries out what that word means. Software picks a power state by writing a 2-bit code. The block takes only the two codes it supports: full-on (D0) and the low-power hot state (D3hot). Any other code is dropped without a trace. While the function sits in D3hot, the block shuts memory and I/O decode and masks interrupts. Configuration access is unaffected, because configuration decode lives outside this block.

When software moves the function from D3hot back to D0, the block issues a warm reset pulse of fixed length to the rest of the function. It also keeps a wake-event status bit that latches every wake event, plus a wake enable. When both are set, they drive a system event flag that is shared with other functions. Only the power-on reset clears these two bits. The platform reset and the warm reset leave them as they are, so a wake that happens across a reset can still be seen afterwards.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After power-on reset the status word reads 0x0000_0000, `decode_en`=1, `irq_block`=0, `warm_rst`=0 and `sys_evt`=0.
- R2: A write with `wr_be[0]`=1 loads the state code from `wr_data[1:0]` when that code is 00 (D0) or 11 (D3hot), and the code reads back at `rd_data[1:0]`. A write with `wr_be[0]`=0 leaves the state code unchanged.
- R3: A write of code 01 or 10 is accepted, but the state code keeps its previous value.
- R4: In D3hot, `decode_en`=0 and `irq_block`=1. In D0, `decode_en`=1 and `irq_block`=0.
- R5: A write that changes the state code from 11 to 00 raises `warm_rst` for exactly WARM_LEN cycles, default 4. The pulse starts in the first cycle in which the code reads 00. A change from 00 to 11, or a rewrite of 00, produces no pulse.
- R6: A cycle with `wake_evt`=1 sets the wake status at bit 15 on the next edge, whatever the wake enable is.
- R7: Writing 1 to bit 15 with `wr_be[1]`=1 clears the wake status. Writing 0 to it leaves the status as it was. A wake event in the same cycle as the clear leaves the status set.
- R8: Bit 8 is the wake enable and is written through `wr_be[1]`. `sys_evt` is 1 exactly when the wake enable and the wake status are both 1.
- R9: Platform reset returns the state code to 00 without a warm reset pulse and keeps bits 8 and 15. Power-on reset clears bits 8 and 15.
- R10: Every bit other than 1:0, 8 and 15 reads 0, even after it has been written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous; leaves the wake bits alone |
| wr_en | input | 1 | Write strobe for the status word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current status word |
| wake_evt | input | 1 | Wake event from the function, one per cycle |
| decode_en | output | 1 | Memory and I/O decode allowed |
| irq_block | output | 1 | Interrupts masked |
| warm_rst | output | 1 | Warm reset pulse to the function |
| sys_evt | output | 1 | Contribution to the shared system event flag |

## Verification
A wrong state code shows at `rd_data[1:0]`, `decode_en` and `irq_block` on the edge right after the faulty write. A wrong wake status or enable shows at `rd_data` bits 15 and 8, and at `sys_evt`, on the edge after the event or write. A counter that loads the wrong count or misses the D3hot exit only shows up when `warm_rst` is counted over the whole pulse. The bench therefore measures every exit pulse from start to end and checks that no other state change raises it. The stickiness across resets can only be seen after a platform reset pulse, by reading back the wake bits and the state code.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

  localparam int WORD_W   = 32;
  localparam int BE_W     = WORD_W / 8;
  localparam int WEN_BIT  = 8;
  localparam int WSTS_BIT = 15;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D3HOT = 2'b11
  } pstate_e;

  typedef struct packed {
    logic       st_wr;
    logic [1:0] st_code;
    logic       hi_wr;
    logic       en_val;
    logic       sts_clr;
  } wr_fields_t;

  function automatic logic code_is_legal(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3HOT);
  endfunction

  function automatic logic is_d3_exit(input pstate_e cur, input pstate_e nxt);
    return (cur == PS_D3HOT) && (nxt == PS_D0);
  endfunction

  function automatic wr_fields_t split_write(input logic en,
                                             input logic [BE_W-1:0] be,
                                             input logic [WORD_W-1:0] d);
    wr_fields_t f;
    f.st_wr   = en & be[0];
    f.st_code = d[1:0];
    f.hi_wr   = en & be[1];
    f.en_val  = d[WEN_BIT];
    f.sts_clr = en & be[1] & d[WSTS_BIT];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input pstate_e st,
                                                  input logic en,
                                                  input logic sts);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[1:0]      = st;
    w[WEN_BIT]  = en;
    w[WSTS_BIT] = sts;
    return w;
  endfunction

endpackage

// File: rtl/pmw_state_reg.sv
module pmw_state_reg
  import pmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_code,
  output pstate_e    state_q,
  output logic       exit_evt
);

  pstate_e state_d;
  logic    code_ok;

  assign code_ok = code_is_legal(wr_code);

  always_comb begin
    state_d = state_q;
    if (wr_stb && code_ok) state_d = pstate_e'(wr_code);
  end

  assign exit_evt = is_d3_exit(state_q, state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_D0;
    else        state_q <= state_d;
  end

  a_r3_illegal_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !code_is_legal(wr_code)) |=> $stable(state_q));

  a_r2_legal_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && code_is_legal(wr_code)) |=> (state_q == $past(wr_code)));

endmodule

// File: rtl/pmw_warm_pulse.sv
module pmw_warm_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (fire)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign pulse = (cnt_q != '0);

  a_r5_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);

  a_r5_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !fire) |=> !pulse);

endmodule

// File: rtl/pmw_wake_status.sv
module pmw_wake_status (
  input  logic clk,
  input  logic por_n,
  input  logic wake_evt,
  input  logic en_wr,
  input  logic en_val,
  input  logic sts_clr,
  output logic en_q,
  output logic sts_q
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_val;
      if (wake_evt)     sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
    end
  end

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!por_n)
    wake_evt |=> sts_q);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!por_n)
    (sts_clr && !wake_evt) |=> !sts_q);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (sts_q && !sts_clr) |=> sts_q);

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pmw_pkg::*;
#(
  parameter int WARM_LEN = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              plat_rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wake_evt,
  output logic              decode_en,
  output logic              irq_block,
  output logic              warm_rst,
  output logic              sys_evt
);

  wr_fields_t wf;
  pstate_e    state_q;
  logic       exit_evt;
  logic       hw_rst_n;
  logic       wen_q;
  logic       wsts_q;

  assign wf       = split_write(wr_en, wr_be, wr_data);
  assign hw_rst_n = por_n & plat_rst_n;

  pmw_state_reg u_state (
    .clk      (clk),
    .rst_n    (hw_rst_n),
    .wr_stb   (wf.st_wr),
    .wr_code  (wf.st_code),
    .state_q  (state_q),
    .exit_evt (exit_evt)
  );

  pmw_warm_pulse #(.LEN(WARM_LEN)) u_warm (
    .clk   (clk),
    .rst_n (hw_rst_n),
    .fire  (exit_evt),
    .pulse (warm_rst)
  );

  pmw_wake_status u_wake (
    .clk      (clk),
    .por_n    (por_n),
    .wake_evt (wake_evt),
    .en_wr    (wf.hi_wr),
    .en_val   (wf.en_val),
    .sts_clr  (wf.sts_clr),
    .en_q     (wen_q),
    .sts_q    (wsts_q)
  );

  assign decode_en = (state_q == PS_D0);
  assign irq_block = (state_q == PS_D3HOT);
  assign sys_evt   = wen_q & wsts_q;
  assign rd_data   = pack_word(state_q, wen_q, wsts_q);

  a_r5_exit_from_d3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    exit_evt |-> irq_block);

  a_r4_d3_blocks: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_data[1:0] == 2'b11) |-> (!decode_en && irq_block));

endmodule

// File: tb/tb_pm_wake_ctrl.sv
module tb_pm_wake_ctrl;

  localparam int WARM_LEN = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        plat_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wake_evt = 1'b0;
  logic        decode_en, irq_block, warm_rst, sys_evt;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pm_wake_ctrl #(.WARM_LEN(WARM_LEN)) dut (
    .clk(clk), .por_n(por_n), .plat_rst_n(plat_rst_n),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .wake_evt(wake_evt), .decode_en(decode_en), .irq_block(irq_block),
    .warm_rst(warm_rst), .sys_evt(sys_evt)
  );

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] data;
    logic        wake;
    logic [31:0] exp_rd;
    logic        exp_dec;
    logic        exp_irqb;
    logic        exp_sys;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 32'h0000_0003, 1'b0, 32'h0000_0003, 1'b0, 1'b1, 1'b0}, // R2 R4 enter D3hot
    '{4'h1, 32'h0000_0001, 1'b0, 32'h0000_0003, 1'b0, 1'b1, 1'b0}, // R3 code 01 dropped
    '{4'h1, 32'h0000_0002, 1'b0, 32'h0000_0003, 1'b0, 1'b1, 1'b0}, // R3 code 10 dropped
    '{4'h0, 32'h0000_0000, 1'b0, 32'h0000_0003, 1'b0, 1'b1, 1'b0}, // R2 byte 0 disabled
    '{4'h1, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R4 back to D0
    '{4'h2, 32'h0000_0100, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 1'b0}, // R8 enable
    '{4'h0, 32'h0000_0000, 1'b1, 32'h0000_8100, 1'b1, 1'b0, 1'b1}, // R6 R8 event
    '{4'h2, 32'h0000_8100, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 1'b0}, // R7 clear
    '{4'h0, 32'h0000_0000, 1'b1, 32'h0000_8100, 1'b1, 1'b0, 1'b1}, // R6 event again
    '{4'h2, 32'h0000_0100, 1'b0, 32'h0000_8100, 1'b1, 1'b0, 1'b1}, // R7 write 0 keeps
    '{4'h2, 32'h0000_8100, 1'b1, 32'h0000_8100, 1'b1, 1'b0, 1'b1}, // R7 event beats clear
    '{4'h2, 32'h0000_8000, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R7 R8 clear + disable
    '{4'h0, 32'h0000_0000, 1'b1, 32'h0000_8000, 1'b1, 1'b0, 1'b0}, // R6 R8 disabled event
    '{4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0000_0103, 1'b0, 1'b1, 1'b0}, // R10 all ones
    '{4'h1, 32'h0000_00FC, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 1'b0}, // R10 R2 byte noise
    '{4'hF, 32'hFFFF_7EFC, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R10 R8 clear enable
    '{4'h0, 32'h0000_0000, 1'b1, 32'h0000_8000, 1'b1, 1'b0, 1'b0}  // R6 status again
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // starts at a falling edge, holds inputs across one rising edge
  task automatic drive(input logic [3:0] be, input logic [31:0] d, input logic wk);
    wr_en = (be != 4'h0); wr_be = be; wr_data = d; wake_evt = wk;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0; wake_evt = 1'b0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (!warm_rst) break;
      n++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1; plat_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_data", rd_data, 32'h0);
    chk("R1", "dec/irq/warm/sys", {28'h0, decode_en, irq_block, warm_rst, sys_evt},
        32'h8);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].be, VEC[i].data, VEC[i].wake);
      chk("R2-10 vec", "rd_data", rd_data, VEC[i].exp_rd);
      chk("R4", "decode_en", {31'h0, decode_en}, {31'h0, VEC[i].exp_dec});
      chk("R4", "irq_block", {31'h0, irq_block}, {31'h0, VEC[i].exp_irqb});
      chk("R8", "sys_evt", {31'h0, sys_evt}, {31'h0, VEC[i].exp_sys});
    end
    repeat (8) @(negedge clk);

    // R5 no pulse on entering D3hot
    drive(4'h1, 32'h3, 1'b0);
    pulse_len(n);
    chk("R5", "pulse on D0->D3", n, 0);
    // R5 exit pulse length
    drive(4'h1, 32'h0, 1'b0);
    chk("R5", "code at pulse start", rd_data, 32'h0000_8000);
    pulse_len(n);
    chk("R5", "exit pulse length", n, WARM_LEN);
    // R5 rewrite of D0
    drive(4'h1, 32'h0, 1'b0);
    pulse_len(n);
    chk("R5", "pulse on D0 rewrite", n, 0);

    // R9 platform reset from D3hot keeps wake bits
    drive(4'h2, 32'h0000_0100, 1'b0);
    drive(4'h1, 32'h3, 1'b0);
    chk("R9", "pre-reset word", rd_data, 32'h0000_8103);
    plat_rst_n = 1'b0;
    @(negedge clk);
    plat_rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "word after platform reset", rd_data, 32'h0000_8100);
    chk("R9", "warm_rst after platform reset", {31'h0, warm_rst}, 32'h0);
    chk("R9", "sys_evt kept", {31'h0, sys_evt}, 32'h1);
    // R9 power-on reset clears wake bits
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R9", "word after power-on reset", rd_data, 32'h0);
    chk("R9", "sys_evt after power-on reset", {31'h0, sys_evt}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule